// File: doc/BRIEF.md
# Load/Store Execution Slice

This block executes one instruction per clock for a small register machine, covering memory loads, memory stores and an add-with-constant operation that shares the same adder. A 32-bit instruction word is decoded combinationally. The block computes an effective address from a base register and a sign-extended 16-bit offset, and it drives a single data-memory port with address, write data, output enable and write enable. Read data comes back on the same cycle.

A two-read, one-write register file supplies the base register and the store data. The second read address is steered between two instruction fields, so that a store can read the register named in its destination field. A three-way write-back multiplexer picks the adder result or the memory read data. Its third input is held in reserve for future control-flow use and drives zero. The register file is written on the rising edge. A store never writes it.

Top module: `ldst_slice`

## Requirements
- R1: Field positions: opcode is bits 31:26, destination/data register C is bits 25:21, base register A is bits 20:16, register B is bits 15:11, and the signed offset is bits 15:0. Opcode 0x18 is load, 0x19 is store and 0x30 is add-constant.
- R2: For load, store and add-constant, `mem_addr` equals register A plus the offset sign-extended to 32 bits, with the sum taken modulo 2^32.
- R3: A load asserts `mem_oe`, keeps `mem_we` low, and writes `mem_rdata` into register C at the next rising edge.
- R4: A store asserts `mem_we`, keeps `mem_oe` low, and drives `mem_wdata` with the contents of register C.
- R5: A store leaves every register-file entry unchanged.
- R6: Add-constant writes register A plus the sign-extended offset into register C at the rising edge. It asserts neither memory enable.
- R7: Register 31 always reads as zero, and writes to it are discarded.
- R8: Any opcode other than the three above asserts neither memory enable and changes no register.
- R9: A synchronous reset clears all registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge writes the register file |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word for the current cycle |
| mem_addr | output | 32 | Effective address to data memory |
| mem_wdata | output | 32 | Store data to data memory |
| mem_rdata | input | 32 | Read data returned by data memory in the same cycle |
| mem_oe | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable; memory updates at the end of the cycle |

## Verification
The hardest case to reach from the ports is a load that returns stored data through a different base register and a negative offset. Reaching it needs the register file seeded with distinct bases and the memory written at an exact address first. The bench seeds registers with add-constant, stores through one base, and loads through the other with an offset that points back to the same word. Register contents are visible only through later stores, so every store's write data is compared with a model register file. That comparison also shows whether an earlier store or unknown opcode changed any register.

// File: rtl/ldst_slice.sv
module ldst_slice #(
  parameter int DW      = 32,
  parameter int RW      = 5,
  parameter int LITW    = 16,
  parameter int OPW     = 6,
  parameter logic [5:0] OP_LD   = 6'h18,
  parameter logic [5:0] OP_ST   = 6'h19,
  parameter logic [5:0] OP_ADDC = 6'h30
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [31:0]   instr,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_oe,
  output logic          mem_we
);
  localparam int NREG = 1 << RW;
  localparam logic [RW-1:0] ZR = RW'(NREG - 1);
  localparam logic [1:0] WB_RSV = 2'd0;
  localparam logic [1:0] WB_ALU = 2'd1;
  localparam logic [1:0] WB_MEM = 2'd2;

  logic [OPW-1:0]  op;
  logic [RW-1:0]   f_c, f_a, f_b, ra2;
  logic [LITW-1:0] lit;
  logic [DW-1:0]   sext, rd1, rd2, sum, wb;
  logic            is_ld, is_st, is_addc, ra2sel, rf_we;
  logic [1:0]      wdsel;
  logic [DW-1:0]   rf [NREG];

  assign op  = instr[31:26];
  assign f_c = instr[25:21];
  assign f_a = instr[20:16];
  assign f_b = instr[15:11];
  assign lit = instr[15:0];

  assign is_ld   = (op == OP_LD);
  assign is_st   = (op == OP_ST);
  assign is_addc = (op == OP_ADDC);

  assign ra2sel = is_st;
  assign ra2    = ra2sel ? f_c : f_b;
  assign rf_we  = is_ld | is_addc;
  assign wdsel  = is_ld ? WB_MEM : WB_ALU;

  assign rd1 = (f_a == ZR) ? '0 : rf[f_a];
  assign rd2 = (ra2 == ZR) ? '0 : rf[ra2];

  assign sext = {{(DW-LITW){lit[LITW-1]}}, lit};
  assign sum  = rd1 + sext;

  always_comb begin
    case (wdsel)
      WB_ALU:  wb = sum;
      WB_MEM:  wb = mem_rdata;
      WB_RSV:  wb = '0;
      default: wb = '0;
    endcase
  end

  assign mem_addr  = sum;
  assign mem_wdata = rd2;
  assign mem_oe    = is_ld;
  assign mem_we    = is_st;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (rf_we && f_c != ZR) begin
      rf[f_c] <= wb;
    end
  end
endmodule

module ldst_slice_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] instr,
  input logic [31:0] mem_addr,
  input logic        mem_oe,
  input logic        mem_we,
  input logic        rf_we
);
  logic [5:0] opc;
  assign opc = instr[31:26];

  a_r3_load_reads_only: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h18) |-> (mem_oe && !mem_we));

  a_r4_store_writes_only: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'h19) |-> (mem_we && !mem_oe));

  a_r5_store_keeps_rf: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !rf_we);

  a_r8_other_quiet: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'h18 && opc != 6'h19 && opc != 6'h30) |-> (!mem_oe && !mem_we && !rf_we));

  a_r2_addr_steady: assert property (@(posedge clk) disable iff (rst)
    ($stable(instr) && !$past(rf_we) && !$past(rst)) |-> $stable(mem_addr));
endmodule

bind ldst_slice ldst_slice_chk chk_i (
  .clk(clk), .rst(rst), .instr(instr), .mem_addr(mem_addr),
  .mem_oe(mem_oe), .mem_we(mem_we), .rf_we(rf_we)
);

// File: tb/ldst_slice_tb_top.sv
module ldst_slice_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_oe, mem_we;

  logic [31:0] tbmem [256];
  logic [31:0] mrf [32];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  assign mem_rdata = tbmem[mem_addr[7:0]];

  ldst_slice dut_i (
    .clk(clk), .rst(rst), .instr(instr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_oe(mem_oe), .mem_we(mem_we)
  );

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] c,
                                     input logic [4:0] a, input logic [15:0] lit);
    return {op, c, a, lit};
  endfunction

  function automatic logic [31:0] ea(input logic [31:0] w);
    return mrf[w[20:16]] + {{16{w[15]}}, w[15:0]};
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] w);
    logic [5:0] op;
    logic [4:0] c;
    logic [31:0] rd;
    op = w[31:26];
    c  = w[25:21];
    instr = w;
    #1;
    if (op == 6'h18) begin
      chk("R2", mem_addr, ea(w));
      chk("R3", {mem_oe, mem_we}, 32'd2);
    end else if (op == 6'h19) begin
      chk("R2", mem_addr, ea(w));
      chk("R4", {mem_oe, mem_we}, 32'd1);
      chk("R4", mem_wdata, mrf[c]);
    end else if (op == 6'h30) begin
      chk("R2", mem_addr, ea(w));
      chk("R6", {mem_oe, mem_we}, 32'd0);
    end else begin
      chk("R8", {mem_oe, mem_we}, 32'd0);
    end
    rd = tbmem[ea(w) & 32'hff];
    @(posedge clk);
    if (op == 6'h19) tbmem[ea(w) & 32'hff] = mrf[c];
    if (op == 6'h18 && c != 5'd31) mrf[c] = rd;
    if (op == 6'h30 && c != 5'd31) mrf[c] = ea(w);
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) tbmem[i] = $urandom;
    for (int i = 0; i < 32; i++) mrf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: every register reads zero after reset
    for (int i = 0; i < 32; i++) step(mk(6'h19, 5'(i), 5'd31, 16'(i)));
    // R7: writes to register 31 are discarded
    step(mk(6'h30, 5'd31, 5'd31, 16'h7777));
    step(mk(6'h19, 5'd31, 5'd31, 16'h0));
    step(mk(6'h18, 5'd31, 5'd31, 16'h5));
    step(mk(6'h19, 5'd31, 5'd31, 16'h9));
    // R1 R3 R5: store then reload via a different base and negative offset
    step(mk(6'h30, 5'd1, 5'd31, 16'h0100));
    step(mk(6'h30, 5'd2, 5'd31, 16'h0180));
    step(mk(6'h30, 5'd3, 5'd31, 16'h1234));
    step(mk(6'h19, 5'd3, 5'd1, 16'h0008));
    step(mk(6'h19, 5'd3, 5'd31, 16'h0));
    step(mk(6'h18, 5'd4, 5'd2, 16'hff88));
    step(mk(6'h19, 5'd4, 5'd31, 16'h0));
    chk("R3", mrf[4], 32'h1234);
    // R2: sign extension of a negative offset with wraparound
    step(mk(6'h19, 5'd0, 5'd31, 16'h8000));
    // R6 R8: unknown opcode then observe
    step(mk(6'h3f, 5'd1, 5'd2, 16'hffff));
    step(mk(6'h19, 5'd1, 5'd31, 16'h0));
    for (int n = 0; n < 1500; n++) begin
      logic [5:0] op;
      int sel;
      sel = $urandom_range(0, 9);
      op = (sel < 3) ? 6'h19 : (sel < 5) ? 6'h18 : (sel < 8) ? 6'h30 : 6'($urandom);
      step(mk(op, 5'($urandom), 5'($urandom), 16'($urandom)));
    end
    for (int i = 0; i < 32; i++) step(mk(6'h19, 5'(i), 5'd31, 16'(i)));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule